// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the register storage of a 32-bit processor that runs in one of seven operating modes. An instruction names one of sixteen architectural registers, r0 to r15. The current mode decides which physical register that name reaches. Some registers are shared by every mode. Others are private copies that only one exception mode can see. The datapath gets two combinational read ports and one write port for general registers. It also gets one read/write port for the saved status word of the current mode.

An exception sequencer has a dedicated copy port. In a single cycle it stores a return address into the link register of a target mode, and a status snapshot into the saved status word of that mode. The target mode may differ from the current mode. The current status word, decode, the ALU and the sequencing logic all live outside this block. The mode arrives as a plain input.

Physical storage is 31 registers: sixteen shared slots, with r15 as the program counter, five private high registers for the fast-interrupt mode, and one stack-pointer/link pair for each of the five exception modes. Beside these sit five saved status words. All ports are plain control and data pins. Every access completes in the cycle it is presented, so no port has back-pressure or a handshake.

Top module: `banked_regfile`

## Requirements
- R1: The mode input uses these 5-bit encodings: user 10000, fast interrupt 10001, normal interrupt 10010, supervisor 10011, abort 10111, undefined 11011, system 11111. Any other value maps registers and saved status exactly as user mode does.
- R2: In user and system mode, every index r0 to r14 reaches the same shared physical register. A value written in one of these modes reads back unchanged in the other.
- R3: In fast-interrupt mode, indices r8 to r12 reach five private registers. In every other mode these indices reach the shared registers. Writes through one set never change the other.
- R4: Indices r13 and r14 reach a private pair in each of the five exception modes. User and system mode share one pair.
- R5: Index r15 reaches the same program-counter register in every mode.
- R6: Each exception mode has its own saved status word, reached through the saved-status port while that mode is current. In user or system mode that port reads as zero, and a write through it changes no stored word.
- R7: Writes take effect at the rising clock edge. A read of a register that is being written in the same cycle returns the old value. The two read ports are independent.
- R8: When the copy port is enabled, the link register (index 14) and the saved status word of the copy mode are written at the same edge as any ordinary or saved-status write. If the two writes target the same physical register, the copy-port value is stored.
- R9: After reset, every general register and every saved status word reads zero.
- R10: If the copy mode is user or system, the copy port's link value goes to the shared r14 and its status value is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Current operating mode |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | General write architectural index |
| wr_data | input | 32 | General write data |
| sv_wr_en | input | 1 | Saved-status write enable (current mode) |
| sv_wr_data | input | 32 | Saved-status write data |
| sv_rd_data | output | 32 | Saved status word of the current mode |
| cp_en | input | 1 | Copy port enable |
| cp_mode | input | 5 | Target mode of the copy port |
| cp_lr_data | input | 32 | Link value for the target mode |
| cp_sv_data | input | 32 | Status snapshot for the target mode |

## Verification
Three operations can land on the same edge. An ordinary register write can meet a copy-port link write, and a saved-status write can meet a copy-port status write. The bench provokes both collisions on purpose: it sets the current mode equal to the copy mode, points the ordinary write at r14, and raises both saved-status enables together. It also mixes them freely in a long random phase. A behavioural reference model applies the copy port last, and on every cycle all three read outputs are compared with it. A wrong priority therefore shows up as soon as the colliding register is read.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int IDX_W    = 4;
  localparam int ARCH_N   = 1 << IDX_W;
  localparam int PC_IDX   = ARCH_N - 1;
  localparam int SP_IDX   = ARCH_N - 3;
  localparam int LR_IDX   = ARCH_N - 2;
  localparam int FIQ_LO   = 8;
  localparam int FIQ_N    = 5;
  localparam int EXC_N    = 5;
  localparam int FIQ_BANK = 0;
  localparam int FIQ_BASE = ARCH_N;
  localparam int EXC_BASE = FIQ_BASE + FIQ_N;
  localparam int PHYS_N   = EXC_BASE + 2 * EXC_N;
  localparam int PHYS_W   = $clog2(PHYS_N);
  localparam int BANK_W   = $clog2(EXC_N);

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  typedef struct packed {
    logic              valid;
    logic [BANK_W-1:0] bank;
  } bank_sel_t;

  // Exception bank owned by a mode; valid=0 for user, system and unknown codes.
  function automatic bank_sel_t bank_of(input logic [4:0] m);
    bank_sel_t s;
    s.valid = 1'b1;
    case (m)
      MODE_FIQ: s.bank = BANK_W'(0);
      MODE_IRQ: s.bank = BANK_W'(1);
      MODE_SVC: s.bank = BANK_W'(2);
      MODE_ABT: s.bank = BANK_W'(3);
      MODE_UND: s.bank = BANK_W'(4);
      default: begin
        s.valid = 1'b0;
        s.bank  = '0;
      end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/rf_index_map.sv
module rf_index_map
  import rf_pkg::*;
(
  input  logic [4:0]        mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [PHYS_W-1:0] phys_o
);
  bank_sel_t sel;
  logic      in_fiq_hi;
  logic      is_sp_lr;

  assign sel       = bank_of(mode_i);
  assign in_fiq_hi = sel.valid && (sel.bank == BANK_W'(FIQ_BANK)) &&
                     (idx_i >= IDX_W'(FIQ_LO)) && (idx_i < IDX_W'(FIQ_LO + FIQ_N));
  assign is_sp_lr  = (idx_i == IDX_W'(SP_IDX)) || (idx_i == IDX_W'(LR_IDX));

  always_comb begin
    phys_o = PHYS_W'(idx_i);
    if (idx_i == IDX_W'(PC_IDX)) begin
      phys_o = PHYS_W'(PC_IDX);
    end else if (in_fiq_hi) begin
      phys_o = PHYS_W'(FIQ_BASE) + PHYS_W'(idx_i - IDX_W'(FIQ_LO));
    end else if (sel.valid && is_sp_lr) begin
      phys_o = PHYS_W'(EXC_BASE) + PHYS_W'({sel.bank, 1'b0})
             + PHYS_W'(idx_i == IDX_W'(LR_IDX));
    end
  end

  always_comb begin
    // R5
    if (idx_i == IDX_W'(PC_IDX)) pc_unbanked_chk: assert (phys_o == PHYS_W'(PC_IDX));
    // R2
    if (!sel.valid) shared_identity_chk: assert (phys_o == PHYS_W'(idx_i));
    // R4
    if (sel.valid && is_sp_lr) private_pair_chk: assert (phys_o >= PHYS_W'(EXC_BASE));
  end
endmodule

// File: rtl/rf_gpr_store.sv
module rf_gpr_store
  import rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_RD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHYS_W-1:0] rd_phys_i [N_RD],
  output logic [DATA_W-1:0] rd_data_o [N_RD],
  input  logic              wa_en_i,
  input  logic [PHYS_W-1:0] wa_phys_i,
  input  logic [DATA_W-1:0] wa_data_i,
  input  logic              wb_en_i,
  input  logic [PHYS_W-1:0] wb_phys_i,
  input  logic [DATA_W-1:0] wb_data_i
);
  logic [PHYS_N-1:0][DATA_W-1:0] mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      for (int k = 0; k < PHYS_N; k++) begin
        if (wb_en_i && wb_phys_i == PHYS_W'(k))      mem_q[k] <= wb_data_i;
        else if (wa_en_i && wa_phys_i == PHYS_W'(k)) mem_q[k] <= wa_data_i;
      end
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    assign rd_data_o[p] = mem_q[rd_phys_i[p]];
  end

  // R7
  wa_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en_i && !(wb_en_i && wb_phys_i == wa_phys_i)) |=> mem_q[$past(wa_phys_i)] == $past(wa_data_i));
  // R8
  wb_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_i |=> mem_q[$past(wb_phys_i)] == $past(wb_data_i));
endmodule

// File: rtl/rf_saved_bank.sv
module rf_saved_bank
  import rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        cur_mode_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              cp_en_i,
  input  logic [4:0]        cp_mode_i,
  input  logic [DATA_W-1:0] cp_data_i
);
  bank_sel_t cur_sel;
  bank_sel_t cp_sel;
  logic [EXC_N-1:0][DATA_W-1:0] sv_q;

  assign cur_sel = bank_of(cur_mode_i);
  assign cp_sel  = bank_of(cp_mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_q <= '0;
    end else begin
      for (int k = 0; k < EXC_N; k++) begin
        if (cp_en_i && cp_sel.valid && cp_sel.bank == BANK_W'(k))
          sv_q[k] <= cp_data_i;
        else if (wr_en_i && cur_sel.valid && cur_sel.bank == BANK_W'(k))
          sv_q[k] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = cur_sel.valid ? sv_q[cur_sel.bank] : '0;

  // R6
  no_target_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_sel.valid && !(cp_en_i && cp_sel.valid)) |=> $stable(sv_q));
  // R8
  cp_sv_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_en_i && cp_sel.valid) |=> sv_q[$past(cp_sel.bank)] == $past(cp_data_i));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_i,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sv_wr_en,
  input  logic [DATA_W-1:0] sv_wr_data,
  output logic [DATA_W-1:0] sv_rd_data,
  input  logic              cp_en,
  input  logic [4:0]        cp_mode,
  input  logic [DATA_W-1:0] cp_lr_data,
  input  logic [DATA_W-1:0] cp_sv_data
);
  localparam int N_RD  = 2;
  localparam int N_MAP = N_RD + 2;   // read ports, ordinary write, copy link

  logic [4:0]        map_mode [N_MAP];
  logic [IDX_W-1:0]  map_idx  [N_MAP];
  logic [PHYS_W-1:0] map_phys [N_MAP];
  logic [PHYS_W-1:0] rd_phys  [N_RD];
  logic [DATA_W-1:0] rd_data  [N_RD];

  assign map_mode[0] = mode_i;  assign map_idx[0] = rd_a_idx;
  assign map_mode[1] = mode_i;  assign map_idx[1] = rd_b_idx;
  assign map_mode[2] = mode_i;  assign map_idx[2] = wr_idx;
  assign map_mode[3] = cp_mode; assign map_idx[3] = IDX_W'(LR_IDX);

  for (genvar i = 0; i < N_MAP; i++) begin : g_map
    rf_index_map u_map (
      .mode_i (map_mode[i]),
      .idx_i  (map_idx[i]),
      .phys_o (map_phys[i])
    );
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rdp
    assign rd_phys[p] = map_phys[p];
  end

  rf_gpr_store #(.DATA_W(DATA_W), .N_RD(N_RD)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_phys_i (rd_phys),
    .rd_data_o (rd_data),
    .wa_en_i   (wr_en),
    .wa_phys_i (map_phys[2]),
    .wa_data_i (wr_data),
    .wb_en_i   (cp_en),
    .wb_phys_i (map_phys[3]),
    .wb_data_i (cp_lr_data)
  );

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];

  rf_saved_bank #(.DATA_W(DATA_W)) u_saved (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_mode_i (mode_i),
    .wr_en_i    (sv_wr_en),
    .wr_data_i  (sv_wr_data),
    .rd_data_o  (sv_rd_data),
    .cp_en_i    (cp_en),
    .cp_mode_i  (cp_mode),
    .cp_data_i  (cp_sv_data)
  );

  // R5
  pc_same_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 4'd15 && rd_b_idx == 4'd15) |-> rd_a_data == rd_b_data);
endmodule

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  mode_i;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, sv_wr_data, sv_rd_data;
  logic [31:0] cp_lr_data, cp_sv_data;
  logic        wr_en, sv_wr_en, cp_en;
  logic [4:0]  cp_mode;

  int checks = 0;
  int failures = 0;
  string phase = "R9";

  always #4 clk = ~clk;   // 125 MHz

  banked_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sv_wr_en(sv_wr_en), .sv_wr_data(sv_wr_data), .sv_rd_data(sv_rd_data),
    .cp_en(cp_en), .cp_mode(cp_mode), .cp_lr_data(cp_lr_data), .cp_sv_data(cp_sv_data)
  );

  // Reference model: storage grouped by who owns it.
  logic [31:0] m_common [16];
  logic [31:0] m_fast   [5];
  logic [31:0] m_stack  [5];
  logic [31:0] m_link   [5];
  logic [31:0] m_saved  [5];

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011, SYS = 5'b11111;

  function automatic int owner(input logic [4:0] m);
    if (m == FIQ) return 0;
    if (m == IRQ) return 1;
    if (m == SVC) return 2;
    if (m == ABT) return 3;
    if (m == UND) return 4;
    return -1;
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] m, input logic [3:0] i);
    int o = owner(m);
    if (i == 4'd15) return m_common[15];
    if (o == 0 && i >= 4'd8 && i <= 4'd12) return m_fast[i - 4'd8];
    if (o >= 0 && i == 4'd13) return m_stack[o];
    if (o >= 0 && i == 4'd14) return m_link[o];
    return m_common[i];
  endfunction

  task automatic m_write(input logic [4:0] m, input logic [3:0] i, input logic [31:0] d);
    int o = owner(m);
    if (i == 4'd15) m_common[15] = d;
    else if (o == 0 && i >= 4'd8 && i <= 4'd12) m_fast[i - 4'd8] = d;
    else if (o >= 0 && i == 4'd13) m_stack[o] = d;
    else if (o >= 0 && i == 4'd14) m_link[o] = d;
    else m_common[i] = d;
  endtask

  function automatic string idx_tag(input logic [3:0] i);
    if (i == 4'd15) return "R5";
    if (i == 4'd13 || i == 4'd14) return "R4";
    if (i >= 4'd8 && i <= 4'd12) return "R3";
    return "R2";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s/%s t=%0t actual=%h expected=%h", phase, req, $time, act, exp);
    end
  endtask

  // Inputs are already set after a negedge: compare, let the edge pass, update model.
  task automatic cycle();
    logic [31:0] sv_exp;
    #1;
    check(idx_tag(rd_a_idx), rd_a_data, m_read(mode_i, rd_a_idx));
    check(idx_tag(rd_b_idx), rd_b_data, m_read(mode_i, rd_b_idx));
    sv_exp = (owner(mode_i) < 0) ? 32'h0 : m_saved[owner(mode_i)];
    check("R6", sv_rd_data, sv_exp);
    @(posedge clk);
    if (wr_en) m_write(mode_i, wr_idx, wr_data);
    if (sv_wr_en && owner(mode_i) >= 0) m_saved[owner(mode_i)] = sv_wr_data;
    if (cp_en) begin
      m_write(cp_mode, 4'd14, cp_lr_data);
      if (owner(cp_mode) >= 0) m_saved[owner(cp_mode)] = cp_sv_data;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; sv_wr_en = 0; cp_en = 0;
  endtask

  task automatic wr(input logic [4:0] m, input logic [3:0] i, input logic [31:0] d);
    idle(); mode_i = m; wr_en = 1; wr_idx = i; wr_data = d; cycle(); idle();
  endtask

  task automatic sweep(input logic [4:0] m);
    idle(); mode_i = m;
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i); cycle();
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [4:0] modes [7];
    modes[0] = USR; modes[1] = FIQ; modes[2] = IRQ; modes[3] = SVC;
    modes[4] = ABT; modes[5] = UND; modes[6] = SYS;
    for (int i = 0; i < 16; i++) m_common[i] = '0;
    for (int i = 0; i < 5; i++) begin
      m_fast[i] = '0; m_stack[i] = '0; m_link[i] = '0; m_saved[i] = '0;
    end
    rst_n = 0; mode_i = USR; rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0;
    wr_data = 0; sv_wr_data = 0; cp_mode = USR; cp_lr_data = 0; cp_sv_data = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R9: every mode reads zero after reset
    phase = "R9";
    for (int m = 0; m < 7; m++) sweep(modes[m]);

    // R2: user writes, system reads the same values
    phase = "R2";
    for (int i = 0; i < 16; i++) wr(USR, 4'(i), 32'h1000_0000 + i);
    sweep(SYS);

    // R3/R4: fast-interrupt private registers leave the shared ones intact
    phase = "R3";
    for (int i = 8; i < 15; i++) wr(FIQ, 4'(i), 32'hF000_0000 + i);
    sweep(USR); sweep(FIQ); sweep(IRQ);

    // R4/R6: each exception mode gets its own pair and saved word
    phase = "R4";
    for (int m = 1; m < 6; m++) begin
      wr(modes[m], 4'd13, 32'h5000_0000 + m);
      wr(modes[m], 4'd14, 32'h6000_0000 + m);
      idle(); mode_i = modes[m]; sv_wr_en = 1; sv_wr_data = 32'h7000_0000 + m; cycle(); idle();
    end
    for (int m = 0; m < 7; m++) sweep(modes[m]);

    // R5: PC written in supervisor, seen everywhere
    phase = "R5";
    wr(SVC, 4'd15, 32'h0000_8000);
    for (int m = 0; m < 7; m++) begin
      mode_i = modes[m]; rd_a_idx = 15; rd_b_idx = 15; cycle();
    end

    // R6: saved-status write in user/system has no target
    phase = "R6";
    idle(); mode_i = USR; sv_wr_en = 1; sv_wr_data = 32'hDEAD_0001; cycle();
    mode_i = SYS; sv_wr_data = 32'hDEAD_0002; cycle(); idle();
    for (int m = 1; m < 6; m++) begin mode_i = modes[m]; cycle(); end

    // R7: same-cycle read of the register being written returns old value
    phase = "R7";
    idle(); mode_i = USR; wr_en = 1; wr_idx = 3; wr_data = 32'hAAAA_5555;
    rd_a_idx = 3; rd_b_idx = 3; cycle(); idle();
    rd_a_idx = 3; rd_b_idx = 4; cycle();

    // R8: copy port collides with ordinary and saved-status writes
    phase = "R8";
    idle(); mode_i = IRQ; wr_en = 1; wr_idx = 14; wr_data = 32'h1111_1111;
    sv_wr_en = 1; sv_wr_data = 32'h2222_2222;
    cp_en = 1; cp_mode = IRQ; cp_lr_data = 32'h3333_3333; cp_sv_data = 32'h4444_4444;
    rd_a_idx = 14; rd_b_idx = 13; cycle(); idle();
    rd_a_idx = 14; cycle();
    // copy into another mode while ordinary write proceeds
    mode_i = USR; wr_en = 1; wr_idx = 5; wr_data = 32'h5555_0005;
    cp_en = 1; cp_mode = UND; cp_lr_data = 32'h6666_0006; cp_sv_data = 32'h7777_0007;
    cycle(); idle();
    sweep(UND); sweep(USR);

    // R10: copy with user/system target hits shared r14, drops status
    phase = "R10";
    idle(); mode_i = SVC; cp_en = 1; cp_mode = SYS;
    cp_lr_data = 32'h8888_0008; cp_sv_data = 32'h9999_0009; cycle(); idle();
    sweep(USR);
    for (int m = 1; m < 6; m++) begin mode_i = modes[m]; cycle(); end

    // R1: unknown mode codes behave as user
    phase = "R1";
    wr(5'b00000, 4'd13, 32'hBEEF_0013);
    wr(5'b10110, 4'd9, 32'hBEEF_0009);
    sweep(USR); sweep(5'b01010);

    // Random mix of all ports
    phase = "RND";
    for (int n = 0; n < 3000; n++) begin
      mode_i   = ($urandom_range(0, 9) == 0) ? 5'($urandom) : modes[$urandom_range(0, 6)];
      cp_mode  = ($urandom_range(0, 9) == 0) ? 5'($urandom) : modes[$urandom_range(0, 6)];
      rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
      wr_en = 1'($urandom); wr_idx = 4'($urandom); wr_data = $urandom;
      sv_wr_en = 1'($urandom); sv_wr_data = $urandom;
      cp_en = ($urandom_range(0, 3) == 0); cp_lr_data = $urandom; cp_sv_data = $urandom;
      cycle();
    end
    idle();
    for (int m = 0; m < 7; m++) sweep(modes[m]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule